// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Time Insertion

This block is one output channel of a timer. It watches an up/down count that an external time base puts on a bus. That count climbs from 1 to a peak and then falls back to 1. The channel compares the count against a compare value `cmp_a`. On the way up, a match produces the leading edge of a center-aligned pulse. On the way down, a match produces the trailing edge. A dead-time value `dt_b` delays one of the two edges by that many system clocks. The `trail_mode` input chooses the edge: when it is low, the leading edge is delayed; when it is high, the trailing edge is delayed.

A polarity input sets the level the pin drives while the pulse is active. Two single-cycle force strobes let software move the pin without a real match. A sticky match flag records real compare matches, and a write-one-to-clear strobe clears it. While `freeze` is high, the channel ignores compare matches and holds its dead-time timer. The force strobes still act during `freeze`.

A pulse cycle begins each time the count moves to 1. A delayed edge that would land on or after the next move to 1 is dropped. So an edge never carries into the following cycle, and this is how duty cycles of exactly 0% and 100% arise.

Top module: `cpwm_deadtime`

## Requirements
- R1: After a synchronous active-low reset, `pwm_out` is the inverse of `pol` and `match_flag` is 0.
- R2: With `trail_mode`=1, a match on a rising count (or a count arriving at 1) makes the pin active one clock later. A match on a falling count makes it inactive `dt_b` clocks after that. A `dt_b` of 0 means no delay.
- R3: With `trail_mode`=0, the rising match makes the pin active `dt_b` clocks late, and the falling match makes it inactive at once. If the falling match comes first, or in the same clock, the delayed edge is dropped.
- R4: `cmp_a`=1 gives a 100% active output in steady state.
- R5: `cmp_a` above the peak count gives a 0% (always inactive) output.
- R6: `cmp_a` equal to the peak count holds the pin at the `pol` level once the first match has taken effect.
- R7: A delayed edge still pending when the count moves to 1 is discarded. With peak 8, `trail_mode`=1, `cmp_a`=4 and `dt_b`=3, the output stays 100% active.
- R8: `match_flag` rises on any real compare match. `flag_clr`=1 clears it unless a match arrives in the same clock.
- R9: `force_a` and `force_b`, alone or together, never set `match_flag`.
- R10: The force strobes take effect one clock later. With `trail_mode`=0, `force_a` makes the pin inactive and `force_b` makes it active. With `trail_mode`=1, the two swap roles. Both strobes together always make the pin inactive. A force also cancels any pending delayed edge.
- R11: While `freeze`=1, count changes cause no edge and no flag, but the force strobes act exactly as in R10.
- R12: The pin drives `pol` when active and `~pol` when inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Suspend match detection and the dead-time timer |
| trail_mode | input | 1 | 1: delay the trailing edge; 0: delay the leading edge |
| pol | input | 1 | Active pin level |
| cmp_a | input | W | Compare value; 0 is not a legal setting |
| dt_b | input | W | Dead-time delay in system clocks |
| cnt_bus | input | W | External up/down time-base count |
| force_a | input | 1 | Force strobe A, one clock wide |
| force_b | input | 1 | Force strobe B, one clock wide |
| flag_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| pwm_out | output | 1 | PWM pin |
| match_flag | output | 1 | Sticky real-match flag |

## Verification
A count value on the bus is registered together with the edge it causes. So an undelayed edge and the flag show at the pin one clock after the count is presented. A delayed edge shows `dt_b` clocks after its match, and a force shows one clock after the strobe. The bench presents each count just after a rising edge and reads the outputs 1 ns after the next edge, so every comparison falls in the clock where the result is due. The bench sweeps compare value, dead time, mode and polarity over a peak of 8. It checks the third full pulse cycle against edge positions worked out arithmetically from the phase, by which point every delayed or masked edge has settled.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Pin level for a given active state and polarity.
  function automatic logic drive_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

  // Active state selected by the force strobes. Both together always give
  // inactive, so A wins in lead mode and B wins in trail mode.
  function automatic logic force_target(input logic fa, input logic fb,
                                        input logic trail);
    if (fa && fb) return 1'b0;
    if (trail)    return fa;
    return fb;
  endfunction

  // A match counts as rising when the count went up or just reached 1.
  function automatic logic slope_is_up(input logic went_higher,
                                       input logic at_one);
    return went_higher || at_one;
  endfunction

endpackage

// File: rtl/cpwm_slope_decode.sv
module cpwm_slope_decode #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cnt_bus,
  input  logic [W-1:0] cmp_a,
  output logic         up_hit,
  output logic         dn_hit,
  output logic         bnd
);
  import cpwm_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         moved;
  logic         eq_hit;
  logic         rising;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_bus;
  end

  assign moved  = (cnt_bus != cnt_q);
  assign eq_hit = run && moved && (cnt_bus == cmp_a);
  assign rising = slope_is_up(cnt_bus > cnt_q, cnt_bus == ONE);
  assign up_hit = eq_hit && rising;
  assign dn_hit = eq_hit && !rising;
  assign bnd    = run && moved && (cnt_bus == ONE);

endmodule

// File: rtl/cpwm_dead_timer.sv
module cpwm_dead_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic         load_set,
  input  logic [W-1:0] dly,
  input  logic         cancel,
  input  logic         bnd,
  output logic         fire_set,
  output logic         fire_clr
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         pend_q;
  logic         kind_q;
  logic [W-1:0] left_q;
  logic         expire;

  assign expire   = pend_q && run && (left_q == ONE) && !load && !cancel && !bnd;
  assign fire_set = expire && kind_q;
  assign fire_clr = expire && !kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
      left_q <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      kind_q <= load_set;
      left_q <= dly;
    end else if (cancel || bnd) begin
      pend_q <= 1'b0;
    end else if (pend_q && run) begin
      if (left_q == ONE) pend_q <= 1'b0;
      else               left_q <= left_q - ONE;
    end
  end

  AST_LATE_EDGE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && !load) |=> !(fire_set || fire_clr)); // R7

  AST_FROZEN_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(fire_set || fire_clr)); // R11

endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic trail_mode,
  input  logic force_a,
  input  logic force_b,
  input  logic go_set,
  input  logic go_clr,
  input  logic up_hit,
  input  logic dn_hit,
  input  logic flag_clr,
  output logic pwm_out,
  output logic match_flag,
  output logic active
);
  import cpwm_pkg::*;

  logic act_q;
  logic flag_q;
  logic any_force;

  assign any_force = force_a || force_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (any_force) begin
      act_q <= force_target(force_a, force_b, trail_mode);
    end else if (go_set) begin
      act_q <= 1'b1;
    end else if (go_clr) begin
      act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (up_hit || dn_hit) flag_q <= 1'b1;
    else if (flag_clr)         flag_q <= 1'b0;
  end

  assign active     = act_q;
  assign match_flag = flag_q;
  assign pwm_out    = drive_level(act_q, pol);

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(up_hit || dn_hit)); // R9

  AST_DUAL_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && force_b) |=> !active); // R10

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !up_hit && !dn_hit) |=> !match_flag); // R8

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         trail_mode,
  input  logic         pol,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] dt_b,
  input  logic [W-1:0] cnt_bus,
  input  logic         force_a,
  input  logic         force_b,
  input  logic         flag_clr,
  output logic         pwm_out,
  output logic         match_flag
);
  logic run;
  logic up_hit, dn_hit, bnd;
  logic no_delay;
  logic dir_set, dir_clr;
  logic dly_load, dly_kind;
  logic cancel;
  logic fire_set, fire_clr;
  logic active;

  assign run = !freeze;

  cpwm_slope_decode #(.W(W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cnt_bus(cnt_bus),
    .cmp_a  (cmp_a),
    .up_hit (up_hit),
    .dn_hit (dn_hit),
    .bnd    (bnd)
  );

  // Route each match either straight to the pin or through the timer.
  assign no_delay = (dt_b == '0);
  assign dir_set  = trail_mode ? up_hit : (up_hit && no_delay);
  assign dir_clr  = trail_mode ? (dn_hit && no_delay) : dn_hit;
  assign dly_load = (trail_mode ? dn_hit : up_hit) && !no_delay;
  assign dly_kind = !trail_mode;
  assign cancel   = force_a || force_b || dir_set || dir_clr;

  cpwm_dead_timer #(.W(W)) u_dt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .load    (dly_load),
    .load_set(dly_kind),
    .dly     (dt_b),
    .cancel  (cancel),
    .bnd     (bnd),
    .fire_set(fire_set),
    .fire_clr(fire_clr)
  );

  cpwm_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol       (pol),
    .trail_mode(trail_mode),
    .force_a   (force_a),
    .force_b   (force_b),
    .go_set    (dir_set || fire_set),
    .go_clr    (dir_clr || fire_clr),
    .up_hit    (up_hit),
    .dn_hit    (dn_hit),
    .flag_clr  (flag_clr),
    .pwm_out   (pwm_out),
    .match_flag(match_flag),
    .active    (active)
  );

  AST_FREEZE_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !force_a && !force_b) |=> $stable(active)); // R11

  AST_FORCE_IN_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_mode && force_a && !force_b) |=> active); // R10

  AST_SLOPES_DISJOINT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && !up_hit && !force_a && !force_b) |=> !fire_set && !fire_clr); // R7

endmodule

// File: tb/sim_cpwm_deadtime.sv
module sim_cpwm_deadtime;
  localparam int W    = 8;
  localparam int PK   = 8;
  localparam int LAST = 2 * PK - 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         freeze = 1'b0;
  logic         trail_mode = 1'b0;
  logic         pol = 1'b1;
  logic [W-1:0] cmp_a = 8'd9;
  logic [W-1:0] dt_b = '0;
  logic [W-1:0] cnt_bus = '0;
  logic         force_a = 1'b0;
  logic         force_b = 1'b0;
  logic         flag_clr = 1'b0;
  logic         pwm_out;
  logic         match_flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cpwm_deadtime #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .trail_mode(trail_mode),
    .pol(pol), .cmp_a(cmp_a), .dt_b(dt_b), .cnt_bus(cnt_bus),
    .force_a(force_a), .force_b(force_b), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .match_flag(match_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Present inputs, let one edge pass, settle for sampling.
  task automatic cyc(input int c);
    cnt_bus = W'(c);
    @(posedge clk);
    #1;
  endtask

  function automatic int cnt_at(input int k);
    return (k < PK) ? k + 1 : 2 * PK - 1 - k;
  endfunction

  // Steady-state active level after phase k, from the edge rules.
  function automatic bit exp_act(input bit tr, input int a, input int b, input int k);
    int up_ph, dn_ph, lead_ph, trail_ph;
    bit has_dn, lead_ok, trail_ok;
    if (a > PK) return 1'b0;
    up_ph  = a - 1;
    has_dn = (a >= 2) && (a <= PK - 1);
    dn_ph  = 2 * PK - 1 - a;
    if (tr) begin
      lead_ph  = up_ph;
      lead_ok  = 1'b1;
      trail_ph = dn_ph + b;
      trail_ok = has_dn && (trail_ph < LAST);
    end else begin
      lead_ph  = up_ph + b;
      lead_ok  = (lead_ph < LAST) && !(has_dn && lead_ph >= dn_ph);
      trail_ph = dn_ph;
      trail_ok = has_dn;
    end
    if (!lead_ok)  return 1'b0;
    if (!trail_ok) return 1'b1;
    return (k >= lead_ph) && (k < trail_ph);
  endfunction

  function automatic string tag_of(input bit tr, input bit p, input int a, input int b);
    if (a > PK)  return "R5";
    if (a == PK) return "R6";
    if (a == 1)  return "R4";
    if (tr && (2 * PK - 1 - a + b >= LAST)) return "R7";
    if (!p) return "R12";
    return tr ? "R2" : "R3";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0);
    cyc(0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk);
    #1;
    // Sweep of configurations
    for (int p = 0; p < 2; p++) begin
      for (int tr = 0; tr < 2; tr++) begin
        for (int a = 1; a <= PK + 1; a++) begin
          for (int b = 0; b <= 4; b++) begin
            pol = p[0]; trail_mode = tr[0]; cmp_a = W'(a); dt_b = W'(b);
            do_reset();
            check(pwm_out == ~pol && match_flag == 1'b0, "R1",
                  {pwm_out, match_flag}, {~pol, 1'b0});
            for (int per = 0; per < 3; per++) begin
              for (int k = 0; k < LAST; k++) begin
                cyc(cnt_at(k));
                if (per == 2) begin
                  bit e;
                  e = exp_act(tr[0], a, b, k) ? pol : ~pol;
                  check(pwm_out == e, tag_of(tr[0], p[0], a, b), pwm_out, e);
                end
              end
            end
            check(match_flag == (a <= PK), "R8", match_flag, a <= PK);
          end
        end
      end
    end

    // Flag clear with the count held still
    pol = 1'b1; trail_mode = 1'b1; cmp_a = 8'd3; dt_b = 8'd1;
    do_reset();
    for (int k = 0; k < LAST; k++) cyc(cnt_at(k));
    check(match_flag == 1'b1, "R8", match_flag, 1);
    cyc(5);
    flag_clr = 1'b1; cyc(5); flag_clr = 1'b0;
    check(match_flag == 1'b0, "R8", match_flag, 0);

    // Force strobes, lead mode, no matches possible
    cmp_a = 8'd9; trail_mode = 1'b0;
    do_reset();
    cyc(5);
    force_b = 1'b1; cyc(5); force_b = 1'b0;
    check(pwm_out == 1'b1, "R10", pwm_out, 1);
    check(match_flag == 1'b0, "R9", match_flag, 0);
    force_a = 1'b1; cyc(5); force_a = 1'b0;
    check(pwm_out == 1'b0, "R10", pwm_out, 0);
    force_b = 1'b1; cyc(5); force_b = 1'b0;
    force_a = 1'b1; force_b = 1'b1; cyc(5); force_a = 1'b0; force_b = 1'b0;
    check(pwm_out == 1'b0, "R10", pwm_out, 0);
    check(match_flag == 1'b0, "R9", match_flag, 0);

    // Force strobes, trail mode
    trail_mode = 1'b1;
    force_a = 1'b1; cyc(5); force_a = 1'b0;
    check(pwm_out == 1'b1, "R10", pwm_out, 1);
    force_b = 1'b1; cyc(5); force_b = 1'b0;
    check(pwm_out == 1'b0, "R10", pwm_out, 0);
    force_a = 1'b1; cyc(5); force_a = 1'b0;
    force_a = 1'b1; force_b = 1'b1; cyc(5); force_a = 1'b0; force_b = 1'b0;
    check(pwm_out == 1'b0, "R10", pwm_out, 0);
    check(match_flag == 1'b0, "R9", match_flag, 0);

    // Freeze: matches ignored, forces still act
    cmp_a = 8'd3; dt_b = 8'd0; freeze = 1'b1;
    for (int k = 0; k < LAST; k++) begin
      cyc(cnt_at(k));
      check(pwm_out == 1'b0, "R11", pwm_out, 0);
    end
    check(match_flag == 1'b0, "R11", match_flag, 0);
    force_a = 1'b1; cyc(1); force_a = 1'b0;
    check(pwm_out == 1'b1, "R11", pwm_out, 1);
    force_b = 1'b1; cyc(1); force_b = 1'b0;
    check(pwm_out == 1'b0, "R11", pwm_out, 0);
    check(match_flag == 1'b0, "R9", match_flag, 0);
    freeze = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule